// File: doc/BRIEF.md
# Random Bit Hex UART Streamer

The streamer turns a serial stream of random bits into printable text on a serial line. Several bit generators feed it, each with a data bit and a valid strobe. A select input picks the one being streamed. Accepted bits are shifted together into fixed-width words. The words wait in a small synchronous queue until the transmitter can send them.

The transmitter sends each word as a run of ASCII hexadecimal characters, one character per nibble. Each character goes out in an 8N1 serial frame whose bit period is a fixed number of system clock cycles. The default is 40 cycles, which gives 2.5 Mbit/s from a 100 MHz clock.

When the queue is full, newly packed words are discarded. A sticky flag then records the loss. A change of the select input only applies between words, so one word never holds bits from two generators.

Top module: `rng_hex_streamer`

## Requirements
- R1: After reset `uart_tx` is 1 and `fifo_ovf` is 0, and no frame starts while no bits are accepted.
- R2: With `src_sel` equal to k (0 to NSRC-1), only bits of source k whose `src_vld` bit is 1 are accepted. Bits and strobes of the other sources have no effect on the transmitted text.
- R3: The source used for a word is the one selected on the cycle its first bit is accepted. Changes of `src_sel` while a word is partly packed apply only from the next word.
- R4: A `src_sel` value of NSRC or more accepts no bits and leaves no partial bits behind.
- R5: A word holds WORD_W accepted bits. The first accepted bit becomes the word's most significant bit.
- R6: Each word is sent as WORD_W/4 characters, most significant nibble first. Values 0 to 9 map to bytes 0x30 to 0x39, and values 10 to 15 map to 0x41 to 0x46.
- R7: Each character is framed as one start bit (0), eight data bits least significant first, and one stop bit (1). Every bit lasts CLK_DIV cycles, and the characters of one word follow each other with no gap. The line is 1 when idle.
- R8: Words are sent in the order they were packed. A word taken by the transmitter starts its start bit on the following cycle.
- R9: The queue holds FIFO_DEPTH words besides the one being sent. A word packed while the queue is full is dropped, and stored words are not overwritten. The drop sets `fifo_ovf`, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_bit | input | NSRC | Random data bit of each generator |
| src_vld | input | NSRC | Strobe marking a fresh bit on each generator |
| src_sel | input | SEL_W | Index of the generator to stream |
| uart_tx | output | 1 | Serial text output, idle high |
| fifo_ovf | output | 1 | Sticky flag: a packed word was lost |

## Verification
Nearly every internal fault reaches `uart_tx` within one word time. A bad shift count or selection shows as wrong hex characters in the next frame. A divider error shifts an edge within the first bit period. A queue pointer fault shows as repeated or missing words. The bench keeps a behavioural model of the queue and the serial timing and compares the line and the flag on every clock. A drop-rule fault is therefore seen on the cycle the flag should rise, and the characters are checked against strings written by hand.

// File: rtl/hexstream_pkg.sv
package hexstream_pkg;

  typedef enum logic [0:0] {
    TX_IDLE   = 1'b0,
    TX_ACTIVE = 1'b1
  } tx_state_e;

  localparam int FRAME_BITS = 10;

  // Nibble to printable hex code: digits from 0x30, letters from 0x41.
  function automatic logic [7:0] nib_to_ascii(input logic [3:0] nib);
    if (nib < 4'd10) return 8'h30 + {4'h0, nib};
    else             return 8'h37 + {4'h0, nib};
  endfunction

  // Line level for position idx of a frame carrying ch (0 start, 1..8 data, 9 stop).
  function automatic logic frame_bit(input logic [7:0] ch, input logic [3:0] idx);
    if (idx == 4'd0)      return 1'b0;
    else if (idx <= 4'd8) return ch[3'(idx - 4'd1)];
    else                  return 1'b1;
  endfunction

endpackage

// File: rtl/hs_bit_packer.sv
module hs_bit_packer #(
  parameter int NSRC   = 3,
  parameter int SEL_W  = 2,
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   bit_in,
  input  logic [NSRC-1:0]   bit_vld,
  input  logic [SEL_W-1:0]  src_sel,
  output logic [WORD_W-1:0] word_out,
  output logic              word_push
);
  localparam int CNT_W = $clog2(WORD_W);

  logic [CNT_W-1:0]  cnt_q;
  logic [SEL_W-1:0]  cur_q;
  logic [SEL_W-1:0]  sel_eff;
  logic [WORD_W-1:0] acc_q;
  logic [NSRC-1:0]   hit;
  logic              sel_ok;
  logic              bit_take;
  logic              bit_val;
  logic              word_done;

  // Selection may move only while no bits of a word are held.
  assign sel_eff = (cnt_q == '0) ? src_sel : cur_q;
  assign sel_ok  = (int'(sel_eff) < NSRC);

  for (genvar g = 0; g < NSRC; g++) begin : g_hit
    assign hit[g] = sel_ok && (sel_eff == SEL_W'(g));
  end

  always_comb begin
    bit_take = 1'b0;
    bit_val  = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (hit[i]) begin
        bit_take = bit_vld[i];
        bit_val  = bit_in[i];
      end
    end
  end

  assign word_done = bit_take && (cnt_q == CNT_W'(WORD_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      cur_q     <= '0;
      acc_q     <= '0;
      word_out  <= '0;
      word_push <= 1'b0;
    end else begin
      cur_q     <= sel_eff;
      word_push <= word_done;
      if (bit_take) begin
        acc_q <= {acc_q[WORD_W-2:0], bit_val};
        cnt_q <= word_done ? '0 : cnt_q + 1'b1;
      end
      if (word_done) word_out <= {acc_q[WORD_W-2:0], bit_val};
    end
  end

  // R5
  push_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_push |-> $past(bit_take));

  // R3
  sel_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !word_done) |=> (cur_q == $past(cur_q)));

  // R4
  bad_sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_ok) |-> (!bit_take && cnt_q == '0));

endmodule

// File: rtl/hs_word_fifo.sv
module hs_word_fifo #(
  parameter int WORD_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [WORD_W-1:0] push_data,
  input  logic              pop,
  output logic [WORD_W-1:0] pop_data,
  output logic              empty,
  output logic              ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr;
  logic [AW-1:0]     rd_ptr;
  logic [CW-1:0]     count;
  logic              full;
  logic              wr_ok;
  logic              rd_ok;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign wr_ok    = push && !full;
  assign rd_ok    = pop && !empty;
  assign pop_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
    end else begin
      if (wr_ok) wr_ptr <= ptr_next(wr_ptr);
      if (rd_ok) rd_ptr <= ptr_next(rd_ptr);
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push && full) ovf <= 1'b1;
    end
  end

  // R9
  drop_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> $stable(count));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/hs_hex_uart_tx.sv
module hs_hex_uart_tx
  import hexstream_pkg::*;
#(
  parameter int WORD_W  = 8,
  parameter int CLK_DIV = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_empty,
  input  logic [WORD_W-1:0] fifo_data,
  output logic              fifo_pop,
  output logic              tx_line
);
  localparam int NCHAR = WORD_W / 4;
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int CH_W  = (NCHAR > 1) ? $clog2(NCHAR) : 1;

  tx_state_e         state;
  logic [WORD_W-1:0] word_q;
  logic [CH_W-1:0]   char_idx;
  logic [3:0]        bit_idx;
  logic [DIV_W-1:0]  div_cnt;
  logic [7:0]        cur_char;
  logic              bit_end;
  logic              last_bit;
  logic              last_char;

  assign cur_char  = nib_to_ascii(word_q[WORD_W-1 -: 4]);
  assign bit_end   = (div_cnt == DIV_W'(CLK_DIV - 1));
  assign last_bit  = (bit_idx == 4'(FRAME_BITS - 1));
  assign last_char = (char_idx == CH_W'(NCHAR - 1));
  assign fifo_pop  = (state == TX_IDLE) && !fifo_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= TX_IDLE;
      word_q   <= '0;
      char_idx <= '0;
      bit_idx  <= '0;
      div_cnt  <= '0;
      tx_line  <= 1'b1;
    end else begin
      case (state)
        TX_IDLE: begin
          if (fifo_pop) begin
            word_q   <= fifo_data;
            state    <= TX_ACTIVE;
            char_idx <= '0;
            bit_idx  <= '0;
            div_cnt  <= '0;
            tx_line  <= 1'b0;
          end
        end
        default: begin
          if (!bit_end) begin
            div_cnt <= div_cnt + 1'b1;
          end else begin
            div_cnt <= '0;
            if (last_bit) begin
              if (last_char) begin
                state   <= TX_IDLE;
                tx_line <= 1'b1;
              end else begin
                char_idx <= char_idx + 1'b1;
                bit_idx  <= '0;
                word_q   <= word_q << 4;
                tx_line  <= 1'b0;
              end
            end else begin
              bit_idx <= bit_idx + 1'b1;
              tx_line <= frame_bit(cur_char, bit_idx + 4'd1);
            end
          end
        end
      endcase
    end
  end

  // R7
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TX_IDLE) |-> tx_line);

  // R7
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TX_ACTIVE && !bit_end) |=> $stable(tx_line));

  // R8
  start_follows_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |=> (!tx_line && state == TX_ACTIVE));

endmodule

// File: rtl/rng_hex_streamer.sv
module rng_hex_streamer #(
  parameter int NSRC       = 3,
  parameter int SEL_W      = (NSRC > 1) ? $clog2(NSRC) : 1,
  parameter int WORD_W     = 8,
  parameter int FIFO_DEPTH = 8,
  parameter int CLK_DIV    = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_bit,
  input  logic [NSRC-1:0]  src_vld,
  input  logic [SEL_W-1:0] src_sel,
  output logic             uart_tx,
  output logic             fifo_ovf
);
  logic [WORD_W-1:0] pk_word;
  logic              pk_push;
  logic [WORD_W-1:0] fq_data;
  logic              fq_empty;
  logic              fq_pop;

  hs_bit_packer #(.NSRC(NSRC), .SEL_W(SEL_W), .WORD_W(WORD_W)) u_packer (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_in   (src_bit),
    .bit_vld  (src_vld),
    .src_sel  (src_sel),
    .word_out (pk_word),
    .word_push(pk_push)
  );

  hs_word_fifo #(.WORD_W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (pk_push),
    .push_data(pk_word),
    .pop      (fq_pop),
    .pop_data (fq_data),
    .empty    (fq_empty),
    .ovf      (fifo_ovf)
  );

  hs_hex_uart_tx #(.WORD_W(WORD_W), .CLK_DIV(CLK_DIV)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_empty(fq_empty),
    .fifo_data (fq_data),
    .fifo_pop  (fq_pop),
    .tx_line   (uart_tx)
  );

endmodule

// File: tb/rng_hex_streamer_bench.sv
module rng_hex_streamer_bench;
  localparam int NSRC  = 3;
  localparam int W     = 8;
  localparam int DEPTH = 8;
  localparam int DIV   = 40;
  localparam int NCHAR = W / 4;
  localparam int NTOT  = NCHAR * 10 * DIV;
  localparam string HEX = "0123456789ABCDEF";

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] src_bit = '0;
  logic [2:0] src_vld = '0;
  logic [1:0] src_sel = '0;
  logic       uart_tx;
  logic       fifo_ovf;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  rng_hex_streamer u_rng_hex_streamer (
    .clk(clk), .rst_n(rst_n), .src_bit(src_bit), .src_vld(src_vld),
    .src_sel(src_sel), .uart_tx(uart_tx), .fifo_ovf(fifo_ovf)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] mq[$];
  logic [7:0] m_acc, pend_w, cur_word;
  bit         pend_v, m_ovf;
  int         m_cnt, m_cur, busy, eff, sz;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      mq.delete(); m_acc = 0; pend_v = 0; m_ovf = 0; m_cnt = 0; m_cur = 0;
      busy = 0; cur_word = 0;
    end else begin
      sz = mq.size();
      if (busy > 0) busy--;
      else if (sz > 0) begin cur_word = mq.pop_front(); busy = NTOT; end
      if (pend_v) begin
        if (sz == DEPTH) m_ovf = 1;
        else mq.push_back(pend_w);
      end
      pend_v = 0;
      eff = (m_cnt == 0) ? int'(src_sel) : m_cur;
      m_cur = eff;
      if (eff < NSRC && src_vld[eff]) begin
        m_acc = {m_acc[6:0], src_bit[eff]};
        m_cnt++;
        if (m_cnt == W) begin pend_v = 1; pend_w = m_acc; m_cnt = 0; end
      end
    end
  end

  function automatic logic exp_tx();
    int off, ch, b;
    logic [3:0] nib;
    byte c;
    if (busy == 0) return 1'b1;
    off = NTOT - busy;
    ch  = off / (10 * DIV);
    b   = (off % (10 * DIV)) / DIV;
    nib = 4'((cur_word >> (4 * (NCHAR - 1 - ch))) & 8'hF);
    c   = HEX[nib];
    if (b == 0) return 1'b0;
    if (b == 9) return 1'b1;
    return c[b-1];
  endfunction

  // Per-clock comparison of the line and the flag against the model.
  always @(negedge clk) begin
    if (rst_n) begin
      chk(uart_tx === exp_tx(), "R7", "line level vs model", uart_tx, exp_tx());
      chk(fifo_ovf === m_ovf, "R9", "overflow flag vs model", fifo_ovf, m_ovf);
    end
  end

  // ---------------- serial decoder ----------------
  byte rx_q[$];
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && uart_tx == 1'b0) begin : dec_blk
        byte ch;
        ch = 0;
        repeat (DIV / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
          repeat (DIV) @(negedge clk);
          ch[i] = uart_tx;
        end
        repeat (DIV) @(negedge clk);
        chk(uart_tx == 1'b1, "R7", "stop bit", uart_tx, 1);
        rx_q.push_back(ch);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc_in(input logic [2:0] vld, input logic [2:0] din, input logic [1:0] sel);
    @(negedge clk);
    src_vld = vld; src_bit = din; src_sel = sel;
  endtask

  task automatic quiet();
    @(negedge clk);
    src_vld = '0; src_bit = '0;
  endtask

  // Sends w on source s with select s; the other sources toggle noise.
  task automatic send_word(input int s, input logic [7:0] w, input logic [7:0] noise);
    for (int i = 0; i < 8; i++) begin
      logic [2:0] d;
      d = {3{noise[7-i]}};
      d[s] = w[7-i];
      cyc_in(3'b111, d, 2'(s));
    end
  endtask

  task automatic wait_idle();
    repeat (4) @(negedge clk);
    while (busy != 0 || mq.size() != 0 || pend_v) @(negedge clk);
    repeat (DIV) @(negedge clk);
  endtask

  task automatic check_rx(input string exp, input string tag);
    wait_idle();
    chk(rx_q.size() == exp.len(), tag, "character count", rx_q.size(), exp.len());
    for (int i = 0; i < exp.len() && i < rx_q.size(); i++)
      chk(rx_q[i] == exp[i], tag, "character value", rx_q[i], exp[i]);
    rx_q.delete();
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  // ---------------- test sequence ----------------
  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(uart_tx == 1'b1, "R1", "line during reset", uart_tx, 1);
    chk(fifo_ovf == 1'b0, "R1", "flag during reset", fifo_ovf, 0);
    rst_n = 1'b1;
    repeat (50) @(negedge clk);
    chk(uart_tx == 1'b1, "R1", "line idle after reset", uart_tx, 1);
    chk(rx_q.size() == 0, "R1", "no frame without input", rx_q.size(), 0);

    // R5 / R6: packing order and nibble-to-character mapping
    send_word(0, 8'hA5, 8'h00);
    send_word(0, 8'h3F, 8'hFF);
    quiet();
    check_rx("A53F", "R6");

    // R2: only the selected source counts
    send_word(1, 8'hC7, 8'hFF);
    quiet();
    check_rx("C7", "R2");
    send_word(2, 8'h0E, 8'hB4);
    quiet();
    check_rx("0E", "R2");

    // R3: select change mid-word waits for the word boundary
    cyc_in(3'b111, 3'b001, 2'd0);
    cyc_in(3'b111, 3'b100, 2'd0);
    cyc_in(3'b111, 3'b100, 2'd0);
    cyc_in(3'b111, 3'b001, 2'd0);
    cyc_in(3'b111, 3'b100, 2'd2);
    cyc_in(3'b111, 3'b101, 2'd2);
    cyc_in(3'b111, 3'b101, 2'd2);
    cyc_in(3'b111, 3'b100, 2'd2);
    send_word(2, 8'h5B, 8'hFF);
    quiet();
    check_rx("965B", "R3");

    // R4: out-of-range select takes nothing
    for (int i = 0; i < 13; i++) cyc_in(3'b111, 3'(i), 2'd3);
    send_word(0, 8'h12, 8'hAA);
    quiet();
    check_rx("12", "R4");

    // R8 / R9: burst beyond the queue capacity
    chk(fifo_ovf == 1'b0, "R9", "flag before burst", fifo_ovf, 0);
    for (int k = 0; k < 12; k++) send_word(0, 8'(8'h10 + k), 8'h00);
    quiet();
    repeat (4) @(negedge clk);
    chk(fifo_ovf == 1'b1, "R9", "flag after burst", fifo_ovf, 1);
    check_rx("101112131415161718", "R8");
    send_word(0, 8'hEE, 8'h00);
    quiet();
    check_rx("EE", "R9");
    chk(fifo_ovf == 1'b1, "R9", "flag stays set", fifo_ovf, 1);

    // R1: reset clears the flag
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(fifo_ovf == 1'b0, "R1", "flag cleared by reset", fifo_ovf, 0);
    chk(uart_tx == 1'b1, "R1", "line high in reset", uart_tx, 1);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule